// File: doc/BRIEF.md
# Spacer-Field Population Counter

This block counts the set bits of a 32-bit operand over several clock cycles, and no stage of it needs a shifter. The operand is viewed as eight 4-bit fields, and the top bit of each field serves as a spacer. Before the loop starts, the ones that already sit at spacer positions are tallied, and then every spacer is forced high. On each cycle after that, a single borrow subtraction across the whole word removes one set bit from every field that still holds one. The same subtraction drops the spacer of any field that has run empty. A register counts the fields that are still active, loses one for each spacer that falls, and is added into the running total every cycle.

An operand is offered with a one-cycle valid strobe. The unit raises a busy flag while it iterates and ignores new strobes during that time. It then delivers the count together with a single-cycle done pulse. The number of cycles depends on the data: it is one more than the largest number of ones held in the three low bits of any field, so it lies between 1 and 4.

Top module: `popcnt_spacer`

## Requirements
- R1: After a synchronous active-high reset, `busy` and `done` are both low.
- R2: When `start` is high and `busy` is low at a rising edge, the operand is captured and `busy` is high after that edge.
- R3: When `done` is high, `count` equals the number of ones in the captured operand (0 to 32).
- R4: Let m be the largest number of ones among bits [4i+2:4i] over fields i = 0..7. `done` rises exactly 1+m cycles after the capturing edge.
- R5: `done` is high for exactly one cycle. `busy` falls on the same edge at which `done` rises.
- R6: A `start` strobe while `busy` is high is ignored, and the result belongs to the operand captured first.
- R7: An all-zero operand yields 0 after one cycle. An all-ones operand yields 32 after four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operand valid strobe |
| operand | input | 32 | Word to be counted |
| busy | output | 1 | Iteration in progress; start ignored |
| done | output | 1 | One-cycle result valid |
| count | output | 6 | Number of ones, valid with done |

## Verification
The latency varies with the data, so the bench derives the expected cycle count for each operand from its per-field low-bit ones, using the rule in R4. It counts falling edges from the capturing edge until `done` appears, and it flags any early or late pulse. The count is sampled only at the falling edge at which `done` is high. One falling edge later, the bench confirms that `done` has dropped and `busy` is low. A second strobe is injected one cycle after capture to show that it has no effect on the result.

// File: rtl/popcnt_spacer.sv
module popcnt_spacer #(
  parameter int NFIELD = 8,
  parameter int FLEN   = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [NFIELD*FLEN-1:0]            operand,
  output logic                              busy,
  output logic                              done,
  output logic [$clog2(NFIELD*FLEN+1)-1:0]  count
);
  localparam int W  = NFIELD * FLEN;
  localparam int CW = $clog2(W + 1);
  localparam int AW = $clog2(NFIELD + 1);

  function automatic logic [W-1:0] spacer_mask();
    logic [W-1:0] m = '0;
    for (int i = 0; i < NFIELD; i++) m[i*FLEN + FLEN - 1] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] SPC = spacer_mask();

  function automatic logic [CW-1:0] ones(input logic [W-1:0] v);
    logic [CW-1:0] n = '0;
    for (int i = 0; i < NFIELD; i++) n = n + CW'(v[i*FLEN + FLEN - 1]);
    return n;
  endfunction

  logic [W-1:0]  word, prev;
  logic [AW-1:0] act;
  logic [CW-1:0] sum;

  logic [W-1:0]  word_nx, prev_nx;
  logic [AW-1:0] act_nx;
  logic [CW-1:0] sum_nx;

  assign word_nx = word & (word - prev - prev - W'(1));
  assign prev_nx = word_nx & prev;
  assign act_nx  = act - AW'(ones(prev_nx ^ prev));
  assign sum_nx  = sum + CW'(act_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      count <= '0;
      word  <= '0;
      prev  <= '0;
      act   <= '0;
      sum   <= '0;
    end else if (!busy) begin
      done <= 1'b0;
      if (start) begin
        word <= operand | SPC;
        prev <= SPC;
        act  <= AW'(NFIELD);
        sum  <= ones(operand & SPC);
        busy <= 1'b1;
      end
    end else begin
      word <= word_nx;
      prev <= prev_nx;
      act  <= act_nx;
      sum  <= sum_nx;
      if (prev_nx == '0) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        count <= sum_nx;
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (count <= CW'(W)));
  p_spacer_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((prev & ~$past(prev)) == '0));
  p_active_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (act <= $past(act)));
endmodule

// File: tb/sim_popcnt_spacer.sv
module sim_popcnt_spacer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic        busy, done;
  logic [5:0]  count;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  popcnt_spacer u0 (.clk(clk), .rst(rst), .start(start), .operand(operand),
                    .busy(busy), .done(done), .count(count));

  function automatic int pop(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int lat(input logic [31:0] v);
    int m = 0;
    for (int f = 0; f < 8; f++) begin
      int k = int'(v[4*f]) + int'(v[4*f+1]) + int'(v[4*f+2]);
      if (k > m) m = k;
    end
    return 1 + m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] v, input bit poke);
    int n = 0;
    @(negedge clk);
    start = 1'b1; operand = v;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after capture", int'(busy), 1);
    if (poke) begin
      start = 1'b1; operand = ~v;
    end
    while (n < 20) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (done) break;
    end
    if (poke) begin
      check(done && count == 6'(pop(v)), "R6 strobe while busy ignored", int'(count), pop(v));
    end else begin
      check(done && count == 6'(pop(v)), "R3 count", int'(count), pop(v));
    end
    check(n == lat(v), "R4 latency", n, lat(v));
    @(negedge clk);
    check(!done && !busy, "R5 single pulse", int'({done, busy}), 0);
  endtask

  initial begin
    logic [31:0] s = 32'h1357_9bdf;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 reset state", int'({busy, done}), 0);
    rst = 1'b0;
    run(32'h0, 1'b0);
    check(lat(32'h0) == 1, "R7 zero operand latency", lat(32'h0), 1);
    run(32'hffff_ffff, 1'b0);
    check(lat(32'hffff_ffff) == 4, "R7 all-ones latency", lat(32'hffff_ffff), 4);
    for (int i = 0; i < 32; i++) run(32'h1 << i, 1'b0);
    for (int i = 0; i < 32; i++) run(~(32'h1 << i), 1'b0);
    for (int f = 0; f < 16; f++) run({8{4'(f)}}, 1'b0);
    for (int f = 0; f < 8; f++)
      for (int x = 0; x < 16; x++) run(32'(x) << (4*f), 1'b0);
    for (int i = 0; i < 1500; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      run(s, i % 7 == 0);
    end
    run(32'h8888_8888, 1'b1);
    run(32'h7777_7777, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule